// File: doc/BRIEF.md
# Serial TDM Codec Control Port

This block is the digital side of a voice filter/codec. It sits on a time-division serial highway clocked at 2.048 MHz. An active-low strobe opens an 8-bit slot. Within that slot the block sends one PCM byte, MSB first on rising edges, and receives one PCM byte and one control byte on falling edges. A three-level address input, carried here as a 2-bit code, decides what a slot does. The low and middle levels exchange PCM and load the path-control register. The high level loads the drive/test register and mutes the PCM exchange. A second strobe pulse in the same frame can therefore update the drive/test register without disturbing speech.

The path-control register is split into a transmit gain code, a receive gain code and a path mode. The path modes are normal, digital loopback, analog loopback and powerdown. The drive/test register is split into six drive-output enables and a two-bit test selector. In digital loopback, the PCM byte latched from the highway is sent back out in the next slot, and the decoder sees zero.

Top module: `tdm_codec_port`

## Requirements
- R1: On the first rising edge at which `frame_n` is sampled low after being sampled high, a slot opens. From that edge, `pcm_sdo` presents the outgoing byte MSB first, with one bit per rising edge and `pcm_oe` high.
- R2: `pcm_oe` is low, and `pcm_sdo` is 0, whenever no slot is open. A slot closes at the rising edge that follows its eighth bit.
- R3: `pcm_sdi` and `ctl_sdi` are captured on falling edges, starting with the first falling edge of the slot. A byte takes effect only after its eighth bit.
- R4: With address code 00 (low) or 01 (middle), a full slot loads the control byte into the path register and latches the PCM byte. With code 10 or 11 (high), it loads the drive/test register, leaves the path register and latched PCM unchanged, and keeps `pcm_oe` low.
- R5: A full slot at code 00 clears the drive/test register. A full slot at code 01 leaves it unchanged.
- R6: At code 00, a control input held low for the whole slot selects normal operation with both gains at 0. A control input held high selects powerdown.
- R7: The path register is decoded as follows. Bits 2:0 are `tx_gain` (dB of boost). Bits 5:3 are `rx_gain` (dB of cut). Bits 7:6 give the path mode: 00 normal, 01 `dig_loop`, 10 `ana_loop`, 11 `pwr_down`.
- R8: The drive/test register is decoded as follows. Bits 5:0 are `drive_out` (1 = active). Bits 7:6 are `test_mode`: 00 none, 01 transmit filter, 10 receive filter, 11 codec.
- R9: While `dig_loop` is set, a slot sends the last latched PCM input byte instead of `enc_word`, and `dec_word` is 0. Otherwise `dec_word` is the last latched PCM input byte.
- R10: If `frame_n` is sampled high before the eighth bit, the slot closes at that edge, and neither register nor the latched PCM byte changes.
- R11: After reset, the path register reads powerdown with both gains 0, and the drive/test register reads 0.
- R12: A slot that opens while `pwr_down` is set keeps `pcm_oe` low for that whole slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low slot strobe |
| addr_lvl | input | 2 | Address level: 00 low, 01 middle, 1x high |
| pcm_sdi | input | 1 | Serial PCM input |
| ctl_sdi | input | 1 | Serial control input |
| enc_word | input | 8 | Byte from the encoder to send |
| pcm_sdo | output | 1 | Serial PCM output |
| pcm_oe | output | 1 | Output enable for `pcm_sdo` |
| dec_word | output | 8 | Byte handed to the decoder |
| tx_gain | output | 3 | Transmit gain code |
| rx_gain | output | 3 | Receive gain code |
| dig_loop | output | 1 | Digital loopback active |
| ana_loop | output | 1 | Analog loopback active |
| pwr_down | output | 1 | Powerdown active |
| drive_out | output | 6 | Drive-output enables |
| test_mode | output | 2 | Test selector |

## Verification
Two things can meet in one slot: the output byte is chosen at the opening edge, and the path register is rewritten at the slot's last falling edge. A slot can also both leave a mode and enter another. The vector table sets up such slots on purpose. In one, the slot enters digital loopback; in the next, the slot sends the byte echoed from the first while loading a different mode. A powerdown word is written while the output is still live, and the slot after it must stay muted. Each slot is judged at its ports: the eight sampled output bits and enables, and the decoded registers read after the slot.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  typedef enum logic [1:0] {
    LVL_LOW   = 2'b00,
    LVL_MID   = 2'b01,
    LVL_HIGH  = 2'b10,
    LVL_HIGH2 = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    PATH_NORM  = 2'b00,
    PATH_DLOOP = 2'b01,
    PATH_ALOOP = 2'b10,
    PATH_PDOWN = 2'b11
  } path_e;

  // high address level (either upper code) targets the drive/test register
  function automatic logic targets_b(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  // only the low level wipes the drive/test register on a path write
  function automatic logic clears_b(input logic [1:0] lvl);
    return lvl == 2'b00;
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int WORD_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [1:0] addr_lvl,
  output logic       slot_start,
  output logic       slot_active,
  output logic       last_bit,
  output logic [1:0] slot_lvl
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             fr_q;
  logic [CNT_W-1:0] bit_idx;

  assign slot_start = !frame_n && fr_q;
  assign last_bit   = slot_active && (bit_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q        <= 1'b1;
      slot_active <= 1'b0;
      bit_idx     <= '0;
      slot_lvl    <= 2'b00;
    end else begin
      fr_q <= frame_n;
      if (slot_start) begin
        slot_active <= 1'b1;
        bit_idx     <= '0;
        slot_lvl    <= addr_lvl;
      end else if (slot_active) begin
        if (frame_n || bit_idx == LAST) slot_active <= 1'b0;
        else bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  p_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> (slot_active && bit_idx == '0));

  p_early_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && frame_n) |=> !slot_active);

  p_slot_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> !slot_active);

endmodule

// File: rtl/tdm_serdes.sv
module tdm_serdes #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_start,
  input  logic              slot_active,
  input  logic              tx_en,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              pcm_sdi,
  input  logic              ctl_sdi,
  output logic              pcm_sdo,
  output logic              pcm_oe,
  output logic [WORD_W-1:0] rx_pcm,
  output logic [WORD_W-1:0] rx_ctl
);
  localparam int LANES = 2;

  logic [WORD_W-1:0] tx_sh;
  logic              tx_on;
  logic [LANES-1:0]  lane_sdi;

  // transmit: load at the opening edge, shift on later rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      tx_on <= 1'b0;
    end else if (slot_start) begin
      tx_sh <= tx_word;
      tx_on <= tx_en;
    end else if (slot_active) begin
      tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end

  assign pcm_oe  = slot_active && tx_on;
  assign pcm_sdo = pcm_oe && tx_sh[WORD_W-1];

  // receive: one falling-edge shifter per serial lane
  assign lane_sdi = {ctl_sdi, pcm_sdi};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-2:0] sh;
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else if (slot_active) sh <= {sh[WORD_W-3:0], lane_sdi[g]};
    end
  end

  // full word as seen at the eighth falling edge
  assign rx_pcm = {g_lane[0].sh, pcm_sdi};
  assign rx_ctl = {g_lane[1].sh, ctl_sdi};

endmodule

// File: rtl/tdm_ctl_regs.sv
module tdm_ctl_regs
  import tdm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_commit,
  input  logic [1:0]        slot_lvl,
  input  logic [WORD_W-1:0] rx_pcm,
  input  logic [WORD_W-1:0] rx_ctl,
  output logic [WORD_W-1:0] reg_a,
  output logic [WORD_W-1:0] reg_b,
  output logic [WORD_W-1:0] pcm_in_q
);
  localparam logic [WORD_W-1:0] A_RST = {2'b11, {(WORD_W-2){1'b0}}};

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a    <= A_RST;
      reg_b    <= '0;
      pcm_in_q <= '0;
    end else if (rx_commit) begin
      if (targets_b(slot_lvl)) begin
        reg_b <= rx_ctl;
      end else begin
        reg_a    <= rx_ctl;
        pcm_in_q <= rx_pcm;
        if (clears_b(slot_lvl)) reg_b <= '0;
      end
    end
  end

  p_a_hold_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (rx_commit && targets_b(slot_lvl)) |=> ($stable(reg_a) && $stable(pcm_in_q)));

  p_b_keep_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (rx_commit && slot_lvl == LVL_MID) |=> $stable(reg_b));

  p_b_clear_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (rx_commit && slot_lvl == LVL_LOW) |=> (reg_b == '0));

  p_no_partial_r10: assert property (@(negedge clk) disable iff (!rst_n)
    !rx_commit |=> ($stable(reg_a) && $stable(reg_b)));

endmodule

// File: rtl/tdm_codec_port.sv
module tdm_codec_port
  import tdm_pkg::*;
#(
  parameter  int WORD_W = 8,
  localparam int GAIN_W = (WORD_W - 2) / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [1:0]        addr_lvl,
  input  logic              pcm_sdi,
  input  logic              ctl_sdi,
  input  logic [WORD_W-1:0] enc_word,
  output logic              pcm_sdo,
  output logic              pcm_oe,
  output logic [WORD_W-1:0] dec_word,
  output logic [GAIN_W-1:0] tx_gain,
  output logic [GAIN_W-1:0] rx_gain,
  output logic              dig_loop,
  output logic              ana_loop,
  output logic              pwr_down,
  output logic [WORD_W-3:0] drive_out,
  output logic [1:0]        test_mode
);
  logic              slot_start, slot_active, last_bit;
  logic [1:0]        slot_lvl;
  logic              tx_en;
  logic [WORD_W-1:0] tx_word, rx_pcm, rx_ctl, reg_a, reg_b, pcm_in_q;
  path_e             path;

  tdm_slot_timer #(.WORD_W(WORD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .addr_lvl(addr_lvl),
    .slot_start(slot_start), .slot_active(slot_active),
    .last_bit(last_bit), .slot_lvl(slot_lvl)
  );

  tdm_serdes #(.WORD_W(WORD_W)) u_serdes (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .slot_active(slot_active), .tx_en(tx_en), .tx_word(tx_word),
    .pcm_sdi(pcm_sdi), .ctl_sdi(ctl_sdi), .pcm_sdo(pcm_sdo),
    .pcm_oe(pcm_oe), .rx_pcm(rx_pcm), .rx_ctl(rx_ctl)
  );

  tdm_ctl_regs #(.WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rx_commit(last_bit), .slot_lvl(slot_lvl),
    .rx_pcm(rx_pcm), .rx_ctl(rx_ctl), .reg_a(reg_a), .reg_b(reg_b),
    .pcm_in_q(pcm_in_q)
  );

  // path register fields
  assign tx_gain  = reg_a[GAIN_W-1:0];
  assign rx_gain  = reg_a[2*GAIN_W-1:GAIN_W];
  assign path     = path_e'(reg_a[WORD_W-1 -: 2]);
  assign dig_loop = (path == PATH_DLOOP);
  assign ana_loop = (path == PATH_ALOOP);
  assign pwr_down = (path == PATH_PDOWN);

  // drive/test register fields
  assign drive_out = reg_b[WORD_W-3:0];
  assign test_mode = reg_b[WORD_W-1 -: 2];

  // loopback source selection and decoder feed
  assign tx_word  = dig_loop ? pcm_in_q : enc_word;
  assign tx_en    = !targets_b(addr_lvl) && !pwr_down;
  assign dec_word = dig_loop ? '0 : pcm_in_q;

  p_b_slot_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_active && targets_b(slot_lvl)) |-> !pcm_oe);

  p_pd_mute_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && pwr_down) |=> !pcm_oe);

  p_echo_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && dig_loop && !targets_b(addr_lvl))
      |=> (pcm_sdo == pcm_in_q[WORD_W-1]));

endmodule

// File: tb/tdm_codec_port_bench.sv
module tdm_codec_port_bench;

  typedef struct packed {
    logic [1:0] lvl;
    logic [7:0] pcm;
    logic [7:0] ctl;
    logic       oe;
    logic [7:0] word;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] dec;
  } vec_t;

  localparam logic [7:0] ENC = 8'hA7;
  localparam int NV = 12;
  // lvl, pcm in, ctl in, oe expected, word out, path reg, drive/test reg, decoder word
  localparam vec_t VEC [NV] = '{
    '{2'b01, 8'h96, 8'h2B, 1'b0, 8'h00, 8'h2B, 8'h00, 8'h96}, // R12 muted after reset
    '{2'b10, 8'h11, 8'h7F, 1'b0, 8'h00, 8'h2B, 8'h7F, 8'h96}, // R4 high slot
    '{2'b01, 8'h3C, 8'h05, 1'b1, ENC,   8'h05, 8'h7F, 8'h3C}, // R5 mid keeps B
    '{2'b11, 8'h22, 8'h8A, 1'b0, 8'h00, 8'h05, 8'h8A, 8'h3C}, // R4 code 11
    '{2'b00, 8'hE1, 8'h12, 1'b1, ENC,   8'h12, 8'h00, 8'hE1}, // R5 low clears B
    '{2'b00, 8'h5A, 8'h40, 1'b1, ENC,   8'h40, 8'h00, 8'h00}, // R9 enter loopback
    '{2'b01, 8'hC3, 8'h40, 1'b1, 8'h5A, 8'h40, 8'h00, 8'h00}, // R9 echo
    '{2'b01, 8'h77, 8'h80, 1'b1, 8'hC3, 8'h80, 8'h00, 8'h77}, // R9 echo, leave
    '{2'b00, 8'h01, 8'hFF, 1'b1, ENC,   8'hFF, 8'h00, 8'h01}, // R6 static high
    '{2'b00, 8'h6E, 8'h00, 1'b0, 8'h00, 8'h00, 8'h00, 8'h6E}, // R6 static low, R12
    '{2'b10, 8'h33, 8'hA5, 1'b0, 8'h00, 8'h00, 8'hA5, 8'h6E}, // R8 drive/test
    '{2'b01, 8'h09, 8'h3F, 1'b1, ENC,   8'h3F, 8'hA5, 8'h09}  // R7 gains
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [1:0] addr_lvl = 2'b00;
  logic       pcm_sdi = 1'b0;
  logic       ctl_sdi = 1'b0;
  logic [7:0] enc_word = ENC;
  logic       pcm_sdo, pcm_oe, dig_loop, ana_loop, pwr_down;
  logic [7:0] dec_word;
  logic [2:0] tx_gain, rx_gain;
  logic [5:0] drive_out;
  logic [1:0] test_mode;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tdm_codec_port u_tdm_codec_port (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .addr_lvl(addr_lvl),
    .pcm_sdi(pcm_sdi), .ctl_sdi(ctl_sdi), .enc_word(enc_word),
    .pcm_sdo(pcm_sdo), .pcm_oe(pcm_oe), .dec_word(dec_word),
    .tx_gain(tx_gain), .rx_gain(rx_gain), .dig_loop(dig_loop),
    .ana_loop(ana_loop), .pwr_down(pwr_down), .drive_out(drive_out),
    .test_mode(test_mode)
  );

  function automatic logic [7:0] path_reg();
    return {ana_loop | pwr_down, dig_loop | pwr_down, rx_gain, tx_gain};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_slot(input logic [1:0] lvl, input logic [7:0] pw,
                          input logic [7:0] cw, input int nbits,
                          output logic [7:0] got_w, output logic [7:0] got_oe,
                          output logic tail_oe);
    got_w  = '0;
    got_oe = '0;
    @(posedge clk); #2;
    frame_n = 1'b0; addr_lvl = lvl; pcm_sdi = pw[7]; ctl_sdi = cw[7];
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk); #3;
      got_oe[7-i] = pcm_oe;
      got_w[7-i]  = pcm_sdo;
      #9;
      if (i == nbits - 1) frame_n = 1'b1;
      else begin pcm_sdi = pw[6-i]; ctl_sdi = cw[6-i]; end
    end
    @(posedge clk); #3;
    tail_oe = pcm_oe | pcm_sdo;
    @(negedge clk); #2;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] w, oe;
    logic       tail;
    #35 rst_n = 1'b1;
    @(posedge clk); #3;
    // R11 reset state, R2 idle output
    check("R11 path reg", {8'h0, path_reg()}, 16'h00C0);
    check("R11 drive/test reg", {8'h0, test_mode, drive_out}, 16'h0000);
    check("R2 idle output", {14'h0, pcm_oe, pcm_sdo}, 16'h0000);

    for (int v = 0; v < NV; v++) begin
      run_slot(VEC[v].lvl, VEC[v].pcm, VEC[v].ctl, 8, w, oe, tail);
      check("R1/R9/R12 pcm out", {oe, w}, {(VEC[v].oe ? 8'hFF : 8'h00), VEC[v].word});
      check("R2 closed after slot", {15'h0, tail}, 16'h0000);
      check("R3/R4/R6/R7 path reg", {8'h0, path_reg()}, {8'h0, VEC[v].a});
      check("R4/R5/R8 drive/test reg", {8'h0, test_mode, drive_out}, {8'h0, VEC[v].b});
      check("R3/R9 dec word", {8'h0, dec_word}, {8'h0, VEC[v].dec});
    end

    // R10 strobe released after five bits: nothing committed
    run_slot(2'b01, 8'h55, 8'h00, 5, w, oe, tail);
    check("R10 partial out", {oe, w}, {8'hF8, 8'hA0});
    check("R10 closed early", {15'h0, tail}, 16'h0000);
    check("R10 path reg kept", {8'h0, path_reg()}, 16'h003F);
    check("R10 dec word kept", {8'h0, dec_word}, 16'h0009);

    // R10 partial high-level slot leaves drive/test register
    run_slot(2'b10, 8'h00, 8'h00, 3, w, oe, tail);
    check("R10 drive/test kept", {8'h0, test_mode, drive_out}, 16'h00A5);
    report();
  end

endmodule